// File: doc/BRIEF.md
# Zone Access Rights Checker

This block decides, for one access to a user memory zone, whether the requester may read it and whether it may change it. It also produces the byte that goes back into storage. Each zone has an 8-bit access control byte. In that byte a control bit set to 0 switches its feature on. The checker combines this byte with four inputs:

- the single password currently held as verified (its kind and its set number);
- a flag saying that mutual authentication has completed;
- the personalization fuse;
- the stored byte and the byte the host proposes.

Password checking and the authentication arithmetic are outside the block. Their outcomes arrive as plain inputs. One request is presented per cycle with `req_valid`. One cycle later the checker returns a registered verdict and both data bytes, with `rsp_valid` high. A zone whose control byte names the same password set as another zone is opened by the same verified password, so such zones behave as one larger zone.

Top module: `zone_access_checker`

## Requirements
- R1: While `rst_n` is low, all outputs are 0. A request accepted at one rising edge produces `rsp_valid`=1 and its results after that same edge, and `rsp_valid` is 0 after any edge with no request.
- R2: When control bit 7 is 0, a write is allowed only while the verified password is a write password of the zone's set.
- R3: When control bit 7 is 1 and `pers_fuse` is 0, a write needs no password.
- R4: While `pers_fuse` is 1, writes need the zone's write password whatever the value of bit 7.
- R5: When control bit 6 is 0, a read needs a verified read or write password of the zone's set. When bit 6 is 1, reads need no password.
- R6: When control bit 5 is 0, both read and write also need `auth_ok`=1. When bit 5 is 1, `auth_ok` has no effect.
- R7: Control bits 4..2 give the zone's password set. A verified password counts only when `pw_set` equals that field, so zones naming the same set open together.
- R8: When control bit 1 is 0, no write is allowed, even with a verified write password.
- R9: When control bit 0 is 0 and the write is allowed, `wr_byte` is the bitwise AND of `old_byte` and `new_byte`. When bit 0 is 1, `wr_byte` is `new_byte`.
- R10: `rd_data` is `old_byte` when the read is allowed and 0x00 when it is denied.
- R11: When the write is denied, `wr_byte` equals `old_byte`.
- R12: `pw_valid`=0 means no password is verified. `pw_is_read`=1 marks a read password and 0 marks a write password.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| acc_reg | input | 8 | Zone access control byte (0 enables each feature) |
| pw_valid | input | 1 | A password is currently verified |
| pw_is_read | input | 1 | Verified password kind: 1 read, 0 write |
| pw_set | input | 3 | Set number of the verified password |
| auth_ok | input | 1 | Authentication completed |
| pers_fuse | input | 1 | Personalization still open (1) |
| old_byte | input | 8 | Byte currently stored |
| new_byte | input | 8 | Byte proposed by the host |
| rsp_valid | output | 1 | Results valid |
| rd_ok | output | 1 | Read allowed |
| wr_ok | output | 1 | Write allowed |
| rd_data | output | 8 | Byte returned to the reader |
| wr_byte | output | 8 | Byte to store back |

## Verification
The hardest case to reach is the one where the personalization override collides with the other write gates. In that case bit 7 says writes are free, the fuse is still open, and a write password is verified but belongs to a different set, or the zone is modify-forbidden, or authentication is missing. The stimulus reaches every such combination by sweeping all 256 control byte values. Each value is crossed with four password states (none, read of the zone's set, write of the zone's set, write of another set), with both authentication values and with both fuse values. Directed vectors then pin down zone sharing, the password kind encoding and the data merge values.

// File: rtl/zac_pkg.sv
package zac_pkg;
  typedef enum logic {
    PWK_WRITE = 1'b0,
    PWK_READ  = 1'b1
  } pw_kind_e;

  typedef struct packed {
    logic need_wpw;
    logic need_rpw;
    logic need_auth;
    logic no_modify;
    logic prog_only;
  } zone_ctl_t;
endpackage

// File: rtl/zac_decode.sv
module zac_decode
  import zac_pkg::*;
#(
  parameter int SET_W = 3,
  localparam int ACC_W = SET_W + 5
) (
  input  logic [ACC_W-1:0] acc_reg,
  input  logic             pers_fuse,
  output zone_ctl_t        ctl,
  output logic [SET_W-1:0] set_sel
);
  localparam int PGO_B  = 0;
  localparam int MDF_B  = 1;
  localparam int SET_LO = 2;
  localparam int ATE_B  = SET_LO + SET_W;
  localparam int RPE_B  = ATE_B + 1;
  localparam int WPE_B  = RPE_B + 1;

  function automatic logic enabled(input logic bitval);
    return ~bitval;
  endfunction

  always_comb begin
    // an open personalization phase overrides the stored write-password bit
    ctl.need_wpw  = enabled(acc_reg[WPE_B]) | pers_fuse;
    ctl.need_rpw  = enabled(acc_reg[RPE_B]);
    ctl.need_auth = enabled(acc_reg[ATE_B]);
    ctl.no_modify = enabled(acc_reg[MDF_B]);
    ctl.prog_only = enabled(acc_reg[PGO_B]);
    set_sel       = acc_reg[SET_LO +: SET_W];
  end
endmodule

// File: rtl/zac_grant.sv
module zac_grant
  import zac_pkg::*;
#(
  parameter int SET_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  zone_ctl_t        ctl,
  input  logic [SET_W-1:0] set_sel,
  input  logic             pw_valid,
  input  logic             pw_is_read,
  input  logic [SET_W-1:0] pw_set,
  input  logic             auth_ok,
  output logic             rd_grant,
  output logic             wr_grant
);
  pw_kind_e pw_kind;
  logic     set_hit;
  logic     hit_wpw;
  logic     hit_rpw;
  logic     auth_pass;

  function automatic logic gate(input logic needed, input logic held);
    return ~needed | held;
  endfunction

  always_comb begin
    pw_kind   = pw_kind_e'(pw_is_read);
    set_hit   = pw_valid & (pw_set == set_sel);
    hit_wpw   = set_hit & (pw_kind == PWK_WRITE);
    hit_rpw   = set_hit & (pw_kind == PWK_READ);
    auth_pass = gate(ctl.need_auth, auth_ok);
    // a write password always grants read as well
    rd_grant  = auth_pass & gate(ctl.need_rpw, hit_rpw | hit_wpw);
    wr_grant  = auth_pass & ~ctl.no_modify & gate(ctl.need_wpw, hit_wpw);
  end

  // R12
  one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_wpw, hit_rpw}));

  // R6
  auth_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.need_auth && !auth_ok) |-> (!rd_grant && !wr_grant));
endmodule

// File: rtl/zac_merge.sv
module zac_merge #(
  parameter int DATA_W = 8
) (
  input  logic              prog_only,
  input  logic              rd_grant,
  input  logic              wr_grant,
  input  logic [DATA_W-1:0] old_byte,
  input  logic [DATA_W-1:0] new_byte,
  output logic [DATA_W-1:0] rd_byte,
  output logic [DATA_W-1:0] wr_byte
);
  logic [DATA_W-1:0] merged;

  function automatic logic [DATA_W-1:0] clear_only(
    input logic [DATA_W-1:0] cur, input logic [DATA_W-1:0] nxt);
    return cur & nxt;
  endfunction

  always_comb begin
    merged  = prog_only ? clear_only(old_byte, new_byte) : new_byte;
    wr_byte = wr_grant ? merged : old_byte;
    rd_byte = rd_grant ? old_byte : '0;
  end
endmodule

// File: rtl/zone_access_checker.sv
module zone_access_checker
  import zac_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SET_W  = 3,
  localparam int ACC_W = SET_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ACC_W-1:0]  acc_reg,
  input  logic              pw_valid,
  input  logic              pw_is_read,
  input  logic [SET_W-1:0]  pw_set,
  input  logic              auth_ok,
  input  logic              pers_fuse,
  input  logic [DATA_W-1:0] old_byte,
  input  logic [DATA_W-1:0] new_byte,
  output logic              rsp_valid,
  output logic              rd_ok,
  output logic              wr_ok,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] wr_byte
);
  localparam int PGO_B  = 0;
  localparam int MDF_B  = 1;
  localparam int SET_LO = 2;

  zone_ctl_t         ctl;
  logic [SET_W-1:0]  set_sel;
  logic              rd_grant;
  logic              wr_grant;
  logic [DATA_W-1:0] rd_byte_c;
  logic [DATA_W-1:0] wr_byte_c;

  zac_decode #(.SET_W(SET_W)) u_decode (
    .acc_reg   (acc_reg),
    .pers_fuse (pers_fuse),
    .ctl       (ctl),
    .set_sel   (set_sel)
  );

  zac_grant #(.SET_W(SET_W)) u_grant (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .set_sel    (set_sel),
    .pw_valid   (pw_valid),
    .pw_is_read (pw_is_read),
    .pw_set     (pw_set),
    .auth_ok    (auth_ok),
    .rd_grant   (rd_grant),
    .wr_grant   (wr_grant)
  );

  zac_merge #(.DATA_W(DATA_W)) u_merge (
    .prog_only (ctl.prog_only),
    .rd_grant  (rd_grant),
    .wr_grant  (wr_grant),
    .old_byte  (old_byte),
    .new_byte  (new_byte),
    .rd_byte   (rd_byte_c),
    .wr_byte   (wr_byte_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rd_ok     <= 1'b0;
      wr_ok     <= 1'b0;
      rd_data   <= '0;
      wr_byte   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rd_ok   <= rd_grant;
        wr_ok   <= wr_grant;
        rd_data <= rd_byte_c;
        wr_byte <= wr_byte_c;
      end
    end
  end

  // R1
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R1
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R8
  no_modify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !acc_reg[MDF_B]) |=> !wr_ok);

  // R9
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !acc_reg[PGO_B]) |=> ((wr_byte & ~$past(old_byte)) == '0));

  // R4
  pers_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pers_fuse &&
     !(pw_valid && !pw_is_read && pw_set == acc_reg[SET_LO +: SET_W]))
    |=> !wr_ok);

  // R10
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rd_ok) |-> (rd_data == '0));

  // R11
  wr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !wr_ok) |-> (wr_byte == $past(old_byte)));
endmodule

// File: tb/zone_access_checker_test.sv
`timescale 1ns/1ps
module zone_access_checker_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] acc_reg = '0;
  logic       pw_valid = 1'b0;
  logic       pw_is_read = 1'b0;
  logic [2:0] pw_set = '0;
  logic       auth_ok = 1'b0;
  logic       pers_fuse = 1'b0;
  logic [7:0] old_byte = '0;
  logic [7:0] new_byte = '0;
  logic       rsp_valid, rd_ok, wr_ok;
  logic [7:0] rd_data, wr_byte;

  int  applied = 0;
  int  bad = 0;
  bit  done = 1'b0;

  typedef struct {
    logic       rd;
    logic       wr;
    logic [7:0] rdat;
    logic [7:0] wdat;
    string      tag;
  } exp_t;

  exp_t q[$];

  always #2.5 clk = ~clk;

  zone_access_checker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_reg(acc_reg),
    .pw_valid(pw_valid), .pw_is_read(pw_is_read), .pw_set(pw_set),
    .auth_ok(auth_ok), .pers_fuse(pers_fuse), .old_byte(old_byte),
    .new_byte(new_byte), .rsp_valid(rsp_valid), .rd_ok(rd_ok),
    .wr_ok(wr_ok), .rd_data(rd_data), .wr_byte(wr_byte)
  );

  // Reference model written from the requirement list (R2 to R12).
  function automatic exp_t predict(input logic [7:0] a, input logic pv,
      input logic pr, input logic [2:0] ps, input logic au, input logic pf,
      input logic [7:0] ob, input logic [7:0] nb);
    exp_t e;
    logic wr_needed, own_w, own_r, auth_fine;
    wr_needed = pf ? 1'b1 : (a[7] == 1'b0);
    own_w     = (pv == 1'b1) && (pr == 1'b0) && (ps == a[4:2]);
    own_r     = (pv == 1'b1) && (pr == 1'b1) && (ps == a[4:2]);
    auth_fine = a[5] ? 1'b1 : au;
    e.rd = auth_fine && (a[6] || own_r || own_w);
    e.wr = auth_fine && a[1] && (wr_needed ? own_w : 1'b1);
    e.rdat = e.rd ? ob : 8'h00;
    if (!e.wr)      e.wdat = ob;
    else if (a[0])  e.wdat = nb;
    else            e.wdat = ob & nb;
    if (!a[1])           e.tag = "R8";
    else if (!a[0])      e.tag = "R9";
    else if (pf)         e.tag = "R4";
    else if (!a[5])      e.tag = "R6";
    else if (!a[6])      e.tag = "R5";
    else if (!a[7])      e.tag = "R2";
    else                 e.tag = "R3";
    return e;
  endfunction

  task automatic apply(input logic [7:0] a, input logic pv, input logic pr,
      input logic [2:0] ps, input logic au, input logic pf,
      input logic [7:0] ob, input logic [7:0] nb, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; acc_reg = a; pw_valid = pv; pw_is_read = pr;
    pw_set = ps; auth_ok = au; pers_fuse = pf; old_byte = ob; new_byte = nb;
    e = predict(a, pv, pr, ps, au, pf, ob, nb);
    if (tag != "") e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item for each response.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) begin
        applied++; bad++;
        $display("FAIL R1: unexpected response rsp_valid=1 expected 0");
      end else begin
        exp_t e;
        e = q.pop_front();
        applied++;
        if (rd_ok !== e.rd || wr_ok !== e.wr ||
            rd_data !== e.rdat || wr_byte !== e.wdat) begin
          bad++;
          $display("FAIL %s: acc=%h got rd=%0b wr=%0b rdat=%h wdat=%h expected rd=%0b wr=%0b rdat=%h wdat=%h",
                   e.tag, uut.acc_reg, rd_ok, wr_ok, rd_data, wr_byte,
                   e.rd, e.wr, e.rdat, e.wdat);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      applied++; bad++;
      $display("FAIL R1: watchdog expired, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_bit("R1", rsp_valid, 1'b0);
    check_bit("R1", rd_ok, 1'b0);
    check_bit("R1", wr_ok, 1'b0);
    check_bit("R1", (rd_data == 8'h00 && wr_byte == 8'h00), 1'b1);
    @(negedge clk); rst_n = 1'b1;

    // R12: no verified password even though kind and set would match
    apply(8'h37, 1'b0, 1'b0, 3'd5, 1'b1, 1'b0, 8'h11, 8'h22, "R12");
    apply(8'h37, 1'b1, 1'b1, 3'd5, 1'b1, 1'b0, 8'h11, 8'h22, "R12");
    // R7: zones on the same set open together, another set stays shut
    apply(8'h37, 1'b1, 1'b0, 3'd5, 1'b1, 1'b0, 8'h5A, 8'hA5, "R7");
    apply(8'h36, 1'b1, 1'b0, 3'd5, 1'b1, 1'b0, 8'h5A, 8'hA5, "R7");
    apply(8'h2B, 1'b1, 1'b0, 3'd5, 1'b1, 1'b0, 8'h5A, 8'hA5, "R7");
    // R10: denied read returns zero, granted read returns stored byte
    apply(8'hB7, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 8'hC3, 8'h3C, "R10");
    apply(8'hB7, 1'b1, 1'b1, 3'd5, 1'b1, 1'b0, 8'hC3, 8'h3C, "R10");
    // R11: denied write keeps the stored byte
    apply(8'h37, 1'b0, 1'b0, 3'd5, 1'b1, 1'b0, 8'hA5, 8'h0F, "R11");
    // R9: clear-only merge
    apply(8'hF6, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 8'hF0, 8'h3C, "R9");
    apply(8'hF6, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 8'h0F, 8'hFF, "R9");
    // R8: modify forbidden even with the write password
    apply(8'h35, 1'b1, 1'b0, 3'd5, 1'b1, 1'b0, 8'h77, 8'h00, "R8");
    // R4 and R3: personalization override
    apply(8'hFF, 1'b0, 1'b0, 3'd7, 1'b0, 1'b1, 8'h12, 8'h34, "R4");
    apply(8'hFF, 1'b1, 1'b0, 3'd7, 1'b0, 1'b1, 8'h12, 8'h34, "R4");
    apply(8'hFF, 1'b0, 1'b0, 3'd7, 1'b0, 1'b0, 8'h12, 8'h34, "R3");
    // R6: authentication gate
    apply(8'hDF, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 8'h99, 8'h66, "R6");
    apply(8'hDF, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 8'h99, 8'h66, "R6");
    // R2 and R5: password gates
    apply(8'h7F, 1'b1, 1'b1, 3'd7, 1'b0, 1'b0, 8'h44, 8'h88, "R2");
    apply(8'h7F, 1'b1, 1'b0, 3'd7, 1'b0, 1'b0, 8'h44, 8'h88, "R2");
    apply(8'hBF, 1'b1, 1'b1, 3'd6, 1'b0, 1'b0, 8'h44, 8'h88, "R5");

    // Full sweep of control bytes against password, auth and fuse states
    for (int a = 0; a < 256; a++) begin
      for (int sc = 0; sc < 4; sc++) begin
        for (int au = 0; au < 2; au++) begin
          for (int pf = 0; pf < 2; pf++) begin
            logic [7:0] av;
            logic [2:0] st;
            av = 8'(a);
            st = (sc == 3) ? av[4:2] + 3'd1 : av[4:2];
            apply(av, sc != 0, sc == 1, st, au[0], pf[0],
                  av ^ 8'h5A, {av[3:0], av[7:4]} ^ 8'(sc), "");
          end
        end
      end
    end

    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R1: every request answered and the idle cycle produces no response
    check_bit("R1", rsp_valid, 1'b0);
    check_bit("R1", q.size() == 0, 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule